// File: doc/BRIEF.md
# Selectable-Polynomial Serial CRC Engine

This block generates and checks frame check sequences on a transparent serial channel. Bytes arrive one per accepted cycle with valid, start-of-frame and end-of-frame strobes. Each byte is run through the selected CRC bit by bit, in an order the caller chooses. A two-bit code picks one of three polynomials: a 16-bit CCITT code, a 16-bit BISYNC code or a 32-bit code. The fourth code is refused as a configuration error, and the register is left as it was.

The transmit side reads `tx_check_o`. This is the finished check value, already laid out as bytes in send order, so the link appends it byte by byte through the same bit order. Whether it is appended is decided per frame outside this block. The receive side feeds the whole frame, check field included, and reads `rx_match_o`. The flag is only a report. A consumer running a pure transparent channel may ignore it.

The mode and the bit order are captured on the start-of-frame byte. They hold until the next start. A change on the inputs in mid-frame therefore cannot corrupt a running remainder.

Top module: `crc_sel_engine`

## Requirements
- R1: Mode code 00 uses polynomial 0x1021 (x^16+x^12+x^5+1). The register is preset to 0xFFFF and the check value is the ones-complement of the remainder.
- R2: Mode code 01 uses polynomial 0x8005 (x^16+x^15+x^2+1). The register is preset to 0x0000 and the check value is the remainder itself.
- R3: Mode code 10 uses polynomial 0x04C11DB7 (the 32-bit CCITT code). The register is preset to 0xFFFFFFFF and the check value is the ones-complement.
- R4: A frame started with mode code 11 sets `cfg_err_o` from the next cycle until a later start with another code. `crc_o` is not changed by any byte of that frame, and `rx_match_o` stays low.
- R5: Each byte is shifted into a non-reflected register, MSB of the register out first. With `rev_i`=0 data bit 0 enters first. With `rev_i`=1 data bit 7 enters first.
- R6: `tx_check_o` places the first byte to send in bits [W-1:W-8] (W=16 or 32), with bits [31:16] zero in 16-bit modes. With order 0 each byte is bit-reversed, so the check value always reaches the line register-MSB first.
- R7: `rx_match_o` is high exactly when `crc_o` equals the mode's residue: 0x1D0F for code 00, 0x0000 for code 01, 0xC704DD7B for code 10.
- R8: A valid byte with `sof_i` high is processed starting from the preset, in that same cycle, whatever the register held before.
- R9: `mode_i` and `rev_i` are sampled only on a valid start byte. Changes on later bytes of the frame have no effect.
- R10: `frame_done_o` is high for exactly the one cycle after a valid byte with `eof_i` high.
- R11: In a cycle with `valid_i` low, `crc_o` does not change, whatever the other inputs do.
- R12: After reset `crc_o` is 0, the mode is 00, the order is 0, `cfg_err_o` and `frame_done_o` are low, and `tx_check_o` is 0x0000FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Polynomial code, sampled on a start byte |
| rev_i | input | 1 | Bit order: 0 = bit 0 first, 1 = bit 7 first |
| valid_i | input | 1 | Byte on `data_i` is accepted this cycle |
| sof_i | input | 1 | Accepted byte is the first of a frame |
| eof_i | input | 1 | Accepted byte is the last of a frame |
| data_i | input | 8 | Data byte |
| crc_o | output | 32 | Running remainder (upper half zero in 16-bit modes) |
| tx_check_o | output | 32 | Check value to append, bytes in send order |
| rx_match_o | output | 1 | Remainder equals the mode's good-frame residue |
| frame_done_o | output | 1 | One-cycle pulse after an end-of-frame byte |
| cfg_err_o | output | 1 | Current frame was started with the reserved code |

## Verification
The nine ASCII digits "1" to "9" are run through all three polynomials in both bit orders, against fixed catalogue check values. Because the digits are asymmetric, this separates a wrong polynomial, a wrong preset or inversion, and a swapped bit order from one another. Pseudo-random frames of several lengths are then compared against a bitwise model after every frame, and each is closed with its own check bytes. This shows that the byte layout of the check value and the residue agree. Directed patterns cover the remaining cases: a corrupted frame, a restart without an end strobe, mode and order toggled mid-frame, idle cycles with busy data lines, and a reserved-code frame.

// File: rtl/crc_sel_pkg.sv
package crc_sel_pkg;

  localparam int BYTE_W    = 8;
  localparam int CRC_MAX_W = 32;
  localparam int NBYTES    = CRC_MAX_W / BYTE_W;

  typedef logic [CRC_MAX_W-1:0] crc_word_t;

  typedef enum logic [1:0] {
    CRC_CCITT16  = 2'b00,
    CRC_BISYNC16 = 2'b01,
    CRC_WIDE32   = 2'b10,
    CRC_RSVD     = 2'b11
  } crc_mode_e;

  function automatic crc_word_t crc_mask(crc_mode_e m);
    case (m)
      CRC_WIDE32: return 32'hFFFF_FFFF;
      CRC_RSVD:   return 32'h0000_0000;
      default:    return 32'h0000_FFFF;
    endcase
  endfunction

  function automatic crc_word_t crc_poly(crc_mode_e m);
    case (m)
      CRC_CCITT16:  return 32'h0000_1021;
      CRC_BISYNC16: return 32'h0000_8005;
      CRC_WIDE32:   return 32'h04C1_1DB7;
      default:      return 32'h0000_0000;
    endcase
  endfunction

  function automatic crc_word_t crc_preset(crc_mode_e m);
    case (m)
      CRC_CCITT16: return 32'h0000_FFFF;
      CRC_WIDE32:  return 32'hFFFF_FFFF;
      default:     return 32'h0000_0000;
    endcase
  endfunction

  function automatic crc_word_t crc_xorout(crc_mode_e m);
    case (m)
      CRC_CCITT16: return 32'h0000_FFFF;
      CRC_WIDE32:  return 32'hFFFF_FFFF;
      default:     return 32'h0000_0000;
    endcase
  endfunction

  function automatic crc_word_t crc_residue(crc_mode_e m);
    case (m)
      CRC_CCITT16: return 32'h0000_1D0F;
      CRC_WIDE32:  return 32'hC704_DD7B;
      default:     return 32'h0000_0000;
    endcase
  endfunction

  // One serial step: the bit leaving the register top meets the incoming bit.
  function automatic crc_word_t crc_step_bit(crc_word_t r, logic din, crc_mode_e m);
    logic      top;
    crc_word_t nxt;
    top = (m == CRC_WIDE32) ? r[CRC_MAX_W-1] : r[15];
    nxt = (r << 1) & crc_mask(m);
    if (top ^ din) nxt = nxt ^ crc_poly(m);
    return nxt;
  endfunction

  // Reverse the bit order inside every byte of the word.
  function automatic crc_word_t byte_flip(crc_word_t v);
    crc_word_t o;
    for (int k = 0; k < NBYTES; k++)
      for (int b = 0; b < BYTE_W; b++)
        o[k*BYTE_W + b] = v[k*BYTE_W + BYTE_W-1-b];
    return o;
  endfunction

endpackage

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl
  import crc_sel_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       sof_i,
  input  logic       eof_i,
  input  logic [1:0] mode_i,
  input  logic       rev_i,
  output crc_mode_e  eff_mode_o,
  output logic       eff_rev_o,
  output logic       load_preset_o,
  output logic       advance_o,
  output crc_mode_e  mode_q_o,
  output logic       rev_q_o,
  output logic       in_frame_o,
  output logic       frame_done_o
);

  logic      start_w;
  logic      end_w;
  crc_mode_e mode_q;
  logic      rev_q;
  logic      in_frame_q;
  logic      done_q;

  assign start_w = valid_i & sof_i;
  assign end_w   = valid_i & eof_i;

  // A start byte uses the fresh settings; every other byte uses the captured ones.
  assign eff_mode_o    = start_w ? crc_mode_e'(mode_i) : mode_q;
  assign eff_rev_o     = start_w ? rev_i : rev_q;
  assign load_preset_o = start_w;
  assign advance_o     = valid_i & (eff_mode_o != CRC_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= CRC_CCITT16;
      rev_q      <= 1'b0;
      in_frame_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= end_w;
      if (start_w) begin
        mode_q     <= crc_mode_e'(mode_i);
        rev_q      <= rev_i;
        in_frame_q <= ~eof_i;
      end else if (end_w) begin
        in_frame_q <= 1'b0;
      end
    end
  end

  assign mode_q_o     = mode_q;
  assign rev_q_o      = rev_q;
  assign in_frame_o   = in_frame_q;
  assign frame_done_o = done_q;

  assert_mode_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame_q && !start_w) |=> ($stable(mode_q) && $stable(rev_q)));

  assert_done_after_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_w |=> frame_done_o);

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_w |=> !frame_done_o);

endmodule

// File: rtl/crc_byte_stepper.sv
module crc_byte_stepper
  import crc_sel_pkg::*;
(
  input  crc_word_t         start_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              rev_i,
  input  crc_mode_e         mode_i,
  output crc_word_t         next_o
);

  crc_word_t chain [0:BYTE_W];

  assign chain[0] = start_i;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
    logic din;
    assign din          = rev_i ? data_i[BYTE_W-1-g] : data_i[g];
    assign chain[g + 1] = crc_step_bit(chain[g], din, mode_i);
  end

  assign next_o = chain[BYTE_W];

endmodule

// File: rtl/crc_check_fmt.sv
module crc_check_fmt
  import crc_sel_pkg::*;
(
  input  crc_word_t crc_i,
  input  crc_mode_e mode_i,
  input  logic      rev_i,
  output crc_word_t tx_check_o,
  output logic      rx_match_o
);

  crc_word_t finished;

  assign finished   = (crc_i ^ crc_xorout(mode_i)) & crc_mask(mode_i);
  assign tx_check_o = rev_i ? finished : byte_flip(finished);
  assign rx_match_o = (mode_i != CRC_RSVD) && (crc_i == crc_residue(mode_i));

endmodule

// File: rtl/crc_sel_engine.sv
module crc_sel_engine
  import crc_sel_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           mode_i,
  input  logic                 rev_i,
  input  logic                 valid_i,
  input  logic                 sof_i,
  input  logic                 eof_i,
  input  logic [BYTE_W-1:0]    data_i,
  output logic [CRC_MAX_W-1:0] crc_o,
  output logic [CRC_MAX_W-1:0] tx_check_o,
  output logic                 rx_match_o,
  output logic                 frame_done_o,
  output logic                 cfg_err_o
);

  crc_mode_e eff_mode;
  logic      eff_rev;
  logic      load_preset;
  logic      advance;
  crc_mode_e mode_q;
  logic      rev_q;
  logic      in_frame;
  crc_word_t crc_q;
  crc_word_t step_start;
  crc_word_t step_next;
  crc_word_t tx_check_w;
  logic      rx_match_w;

  crc_frame_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (valid_i),
    .sof_i         (sof_i),
    .eof_i         (eof_i),
    .mode_i        (mode_i),
    .rev_i         (rev_i),
    .eff_mode_o    (eff_mode),
    .eff_rev_o     (eff_rev),
    .load_preset_o (load_preset),
    .advance_o     (advance),
    .mode_q_o      (mode_q),
    .rev_q_o       (rev_q),
    .in_frame_o    (in_frame),
    .frame_done_o  (frame_done_o)
  );

  assign step_start = load_preset ? crc_preset(eff_mode) : crc_q;

  crc_byte_stepper u_step (
    .start_i (step_start),
    .data_i  (data_i),
    .rev_i   (eff_rev),
    .mode_i  (eff_mode),
    .next_o  (step_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (advance) crc_q <= step_next;
  end

  crc_check_fmt u_fmt (
    .crc_i      (crc_q),
    .mode_i     (mode_q),
    .rev_i      (rev_q),
    .tx_check_o (tx_check_w),
    .rx_match_o (rx_match_w)
  );

  assign crc_o      = crc_q;
  assign tx_check_o = tx_check_w;
  assign rx_match_o = rx_match_w;
  assign cfg_err_o  = (mode_q == CRC_RSVD);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(crc_q));

  assert_reserved_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eff_mode == CRC_RSVD) |=> $stable(crc_q));

  assert_no_match_on_error_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_match_o && cfg_err_o));

  assert_narrow_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != CRC_WIDE32) |-> (tx_check_o[31:16] == 16'h0));

  assert_narrow_reg_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_frame && mode_q != CRC_WIDE32 && mode_q != CRC_RSVD) |-> (crc_q[31:16] == 16'h0));

endmodule

// File: tb/crc_sel_engine_bench.sv
module crc_sel_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        rev_i = 1'b0;
  logic        valid_i = 1'b0;
  logic        sof_i = 1'b0;
  logic        eof_i = 1'b0;
  logic [7:0]  data_i = 8'h00;
  logic [31:0] crc_o;
  logic [31:0] tx_check_o;
  logic        rx_match_o;
  logic        frame_done_o;
  logic        cfg_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  crc_sel_engine u_crc_sel_engine (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_i), .rev_i(rev_i),
    .valid_i(valid_i), .sof_i(sof_i), .eof_i(eof_i), .data_i(data_i),
    .crc_o(crc_o), .tx_check_o(tx_check_o), .rx_match_o(rx_match_o),
    .frame_done_o(frame_done_o), .cfg_err_o(cfg_err_o)
  );

  // mode[34:33] order[32] expected check for the digits "123456789"
  localparam logic [34:0] VEC [6] = '{
    {2'd0, 1'b1, 32'h0000_D64E},
    {2'd1, 1'b1, 32'h0000_FEE8},
    {2'd2, 1'b1, 32'hFC89_1918},
    {2'd0, 1'b0, 32'h0000_6E90},
    {2'd1, 1'b0, 32'h0000_3DBB},
    {2'd2, 1'b0, 32'h2639_F4CB}
  };
  localparam int WIDE_EXP [14] = '{26, 23, 22, 16, 12, 11, 10, 8, 7, 5, 4, 2, 1, 0};

  logic [7:0] msg [0:47];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(int m, bit rv, int n);
    int w;
    logic [31:0] poly, mask, r;
    w = (m == 2) ? 32 : 16;
    mask = (w == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    if (m == 0) poly = (32'd1 << 12) | (32'd1 << 5) | 32'd1;
    else if (m == 1) poly = (32'd1 << 15) | (32'd1 << 2) | 32'd1;
    else begin
      poly = 0;
      foreach (WIDE_EXP[e]) poly |= (32'd1 << WIDE_EXP[e]);
    end
    r = (m == 1) ? 32'h0 : mask;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic inbit, outbit;
        inbit  = rv ? msg[i][7-b] : msg[i][b];
        outbit = r[w-1];
        r = (r << 1) & mask;
        if (inbit != outbit) r = r ^ poly;
      end
    return r;
  endfunction

  function automatic logic [31:0] ref_tx(int m, bit rv, logic [31:0] r);
    logic [31:0] v, o;
    v = (m == 1) ? r : (~r & ((m == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF));
    if (rv) return v;
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 8; b++) o[8*k+b] = v[8*k+7-b];
    return o;
  endfunction

  function automatic logic [31:0] residue(int m);
    return (m == 0) ? 32'h1D0F : (m == 1) ? 32'h0 : 32'hC704_DD7B;
  endfunction

  task automatic put_byte(input int m, input bit rv, input bit s, input bit e, input logic [7:0] d);
    @(negedge clk);
    mode_i = m[1:0]; rev_i = rv; sof_i = s; eof_i = e; data_i = d; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0; data_i = ~d;
  endtask

  // Feed msg[0..n-1]; the last byte carries eof when no check is appended.
  task automatic feed(input int m, input bit rv, input int n, input bit close);
    for (int i = 0; i < n; i++) put_byte(m, rv, i == 0, close && (i == n-1), msg[i]);
  endtask

  // Append the model's check bytes, first byte from the top of the used width.
  task automatic append_check(input int m, input bit rv, input logic [31:0] tx);
    int nb;
    nb = (m == 2) ? 4 : 2;
    for (int k = nb-1; k >= 0; k--) put_byte(m, rv, 1'b0, k == 0, tx[8*k +: 8]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, tx, held;
    repeat (3) @(negedge clk);
    // R12: state out of reset
    chk("R12 crc", crc_o, 32'h0);
    chk("R12 tx_check", tx_check_o, 32'h0000_FFFF);
    chk("R12 cfg_err/done/match", {29'h0, cfg_err_o, frame_done_o, rx_match_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 crc after release", crc_o, 32'h0);

    // Table: catalogue values (R1 R2 R3 R5 R6), then check closes the frame (R7 R10)
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    for (int v = 0; v < 6; v++) begin
      int m; bit rv;
      m = int'(VEC[v][34:33]); rv = VEC[v][32];
      feed(m, rv, 9, 1'b0);
      r = ref_crc(m, rv, 9);
      chk(m == 0 ? "R1 R5 R6 table check" : m == 1 ? "R2 R5 R6 table check" : "R3 R5 R6 table check",
          tx_check_o, VEC[v][31:0]);
      chk("R5 table remainder vs model", crc_o, r);
      chk("R6 model layout", ref_tx(m, rv, r), VEC[v][31:0]);
      append_check(m, rv, VEC[v][31:0]);
      chk("R7 table residue", crc_o, residue(m));
      chk("R7 table match", {31'h0, rx_match_o}, 32'h1);
      chk("R10 table done", {31'h0, frame_done_o}, 32'h1);
      @(negedge clk);
      chk("R10 done one cycle", {31'h0, frame_done_o}, 32'h0);
    end

    // Pseudo-random frames, every mode and order (R1 R2 R3 R5 R7 R8)
    for (int m = 0; m < 3; m++)
      for (int rv = 0; rv < 2; rv++) begin
        int n;
        n = 3 + 7*m + 4*rv;
        for (int i = 0; i < n; i++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          msg[i] = lfsr[7:0];
        end
        feed(m, rv[0], n, 1'b0);
        r = ref_crc(m, rv[0], n);
        chk("R5 R8 random remainder", crc_o, r);
        chk("R6 random check", tx_check_o, ref_tx(m, rv[0], r));
        append_check(m, rv[0], ref_tx(m, rv[0], r));
        chk("R7 random match", {31'h0, rx_match_o}, 32'h1);
      end

    // R7: corrupted frame does not match
    feed(2, 1'b0, 6, 1'b0);
    r = ref_crc(2, 1'b0, 6);
    tx = ref_tx(2, 1'b0, r) ^ 32'h0000_0100;
    append_check(2, 1'b0, tx);
    chk("R7 corrupted no match", {31'h0, rx_match_o}, 32'h0);

    // R8: restart without end strobe begins from the preset
    feed(0, 1'b1, 5, 1'b0);
    feed(0, 1'b1, 4, 1'b1);
    chk("R8 restart from preset", crc_o, ref_crc(0, 1'b1, 4));

    // R9: mode and order changed on later bytes are ignored
    put_byte(1, 1'b1, 1'b1, 1'b0, msg[0]);
    for (int i = 1; i < 6; i++) put_byte(2, 1'b0, 1'b0, i == 5, msg[i]);
    chk("R9 settings frozen", crc_o, ref_crc(1, 1'b1, 6));
    chk("R9 layout frozen", tx_check_o, ref_tx(1, 1'b1, ref_crc(1, 1'b1, 6)));

    // R11: idle cycles with busy data lines
    held = crc_o;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      data_i = 8'(i * 37); sof_i = i[0]; eof_i = i[1]; mode_i = 2'(i);
    end
    @(negedge clk);
    sof_i = 0; eof_i = 0;
    chk("R11 idle hold", crc_o, held);

    // R4: reserved code
    feed(2, 1'b1, 5, 1'b1);
    held = crc_o;
    put_byte(3, 1'b1, 1'b1, 1'b0, 8'h5A);
    chk("R4 cfg_err set", {31'h0, cfg_err_o}, 32'h1);
    put_byte(3, 1'b1, 1'b0, 1'b0, 8'hC3);
    put_byte(3, 1'b1, 1'b0, 1'b1, 8'h0F);
    chk("R4 crc unchanged", crc_o, held);
    chk("R4 no match", {31'h0, rx_match_o}, 32'h0);
    chk("R10 done on reserved frame", {31'h0, frame_done_o}, 32'h1);
    feed(0, 1'b0, 3, 1'b1);
    chk("R4 cfg_err cleared", {31'h0, cfg_err_o}, 32'h0);
    chk("R1 after error", crc_o, ref_crc(0, 1'b0, 3));

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule